// File: doc/BRIEF.md
# External Bus Write Sequencer

This block turns single write requests from an internal master into write cycles on an asynchronous external memory bus. The bus carries a 22-bit address, 16-bit write data with an output-enable for the tristate pad, four active-low memory selects, an active-low I/O select, an active-low boot select, and active-low write and read strobes. It has no read path, so the read strobe stays high.

The block runs on a clock at twice the external bus rate. One clock is half a bus period, which lets it place the select, strobe and data edges on half-period boundaries. The write strobe can be lengthened in three ways: by a programmed waitstate count, by an acknowledge input from the device, or by both. In the combined mode the acknowledge is only looked at once the waitstates are used up. An optional hold phase keeps the write data on the bus for one more bus period after the select is released.

Each request is taken through a valid/ready handshake. The address, data, select code and the three configuration fields are captured when the request is accepted. Ready pulses once, in the last cycle of the bus access, and only one write is in flight at a time.

Top module: `ebw_write_ctrl`

## Requirements
- R1: While reset is high and while idle, every select, the write strobe and the read strobe are high, the data output-enable is low and ready is low.
- R2: Select code 0 to 3 drives memory select 0 to 3 low, code 4 drives the I/O select low, and codes 5, 6 and 7 drive the boot select low. Only one select is ever low at a time, and a select is low whenever the write strobe is low.
- R3: The chosen select goes low and the captured address appears on the bus exactly one clock (half a bus period) before the write strobe falls.
- R4: The write strobe rises exactly one clock before the select rises, and the address is held through that clock.
- R5: With cfg_mode = 2'b00 (waitstates only), the write strobe stays low for 2 + 2W clocks, where W is cfg_waits (0 to 7). The acknowledge input has no effect on this length.
- R6: With cfg_mode = 2'b01 (acknowledge only), cfg_waits is ignored. The acknowledge is sampled on the rising clock edge 2 clocks after the strobe falls and every 2 clocks after that. Each low sample adds 2 clocks of strobe. After the first high sample the strobe stays low for 4 more clocks (two bus periods).
- R7: With cfg_mode = 2'b10 or 2'b11 (combined), acknowledge sampling starts 2 + 2W clocks after the strobe falls and then behaves as in R6.
- R8: The data output-enable is high from the clock in which the strobe falls until one clock after it rises, and bus_dout carries the captured request data throughout.
- R9: When cfg_hold is 1, the output-enable stays high for 2 more clocks after the select has risen, with the strobe and all selects high.
- R10: req_ready is high for exactly one clock: the last clock of the access, which is the clock after the strobe rises without hold, or the second hold clock with hold. A request is accepted only from idle.
- R11: The write strobe stays high for at least 2 clocks (one bus period) between the end of one strobe and the start of the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bus rate |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | One-clock pulse when the access ends |
| req_addr | input | 22 | Write address |
| req_data | input | 16 | Write data |
| req_sel | input | 3 | Select code (0-3 memory, 4 I/O, 5-7 boot) |
| cfg_mode | input | 2 | Stretch mode: 00 waits, 01 ack, 1x both |
| cfg_waits | input | 3 | Waitstate count W |
| cfg_hold | input | 1 | Adds one bus period of data hold |
| bus_ack | input | 1 | Device acknowledge, low means wait |
| bus_addr | output | 22 | External address |
| bus_dout | output | 16 | External write data |
| bus_doe | output | 1 | Data pad output-enable |
| bus_ms_n | output | 4 | Memory selects, active low |
| bus_io_n | output | 1 | I/O select, active low |
| bus_boot_n | output | 1 | Boot select, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_rd_n | output | 1 | Read strobe, held high |

## Verification
The outputs are decoded straight from the registered sequencer state, so every pin changes on the same edge as the state. After an accepting edge the select falls at once, the strobe falls one clock later, and ready arrives one clock (or three with hold) after the strobe rises. The strobe length follows directly from the mode, W and the number of low acknowledge samples. The monitor samples on falling clock edges, counts low-strobe, low-select, output-enable and trailing clocks for each access, and compares them with the queued expectation in the clock where ready is seen. The acknowledge driver releases the input a computed number of falling edges after the strobe falls, so that exactly the intended number of sampling edges see it low.

// File: rtl/ebw_pkg.sv
package ebw_pkg;
    localparam int ADDR_W = 22;
    localparam int DATA_W = 16;
    localparam int SEL_W  = 3;
    localparam int WS_W   = 3;
    localparam int NUM_MS = 4;
    localparam int NUM_CS = NUM_MS + 2;

    typedef enum logic [1:0] {
        MODE_WAITS    = 2'b00,
        MODE_ACK      = 2'b01,
        MODE_BOTH     = 2'b10,
        MODE_BOTH_ALT = 2'b11
    } ext_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_WAIT,
        ST_ACKW,
        ST_FINISH,
        ST_RELEASE,
        ST_HOLD
    } bus_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [SEL_W-1:0]  sel;
        ext_mode_e         mode;
        logic [WS_W-1:0]   waits;
        logic              hold;
    } wr_req_t;

    function automatic logic uses_waits(ext_mode_e m);
        return m != MODE_ACK;
    endfunction

    function automatic logic uses_ack(ext_mode_e m);
        return m != MODE_WAITS;
    endfunction

    // bit i: memory select i; bit NUM_MS: I/O select; bit NUM_MS+1: boot select
    function automatic logic [NUM_CS-1:0] sel_decode(logic [SEL_W-1:0] s);
        logic [NUM_CS-1:0] v;
        v = '0;
        if (s < SEL_W'(NUM_MS))
            v[s] = 1'b1;
        else if (s == SEL_W'(NUM_MS))
            v[NUM_MS] = 1'b1;
        else
            v[NUM_MS+1] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/ebw_req_latch.sv
module ebw_req_latch
    import ebw_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load,
    input  wr_req_t req_in,
    output wr_req_t req_q
);
    always_ff @(posedge clk) begin
        if (rst)
            req_q <= '0;
        else if (load)
            req_q <= req_in;
    end
endmodule

// File: rtl/ebw_seq.sv
module ebw_seq
    import ebw_pkg::*;
#(
    parameter int FINISH_BUS = 2,
    parameter int HOLD_BUS   = 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic            bus_ack,
    input  ext_mode_e       mode,
    input  logic [WS_W-1:0] waits,
    input  logic            hold,
    output logic            accept,
    output logic            done,
    output bus_state_e      state
);
    localparam int CNT_W = WS_W + 3;
    localparam logic [CNT_W-1:0] STROBE_CNT = CNT_W'(1);
    localparam logic [CNT_W-1:0] ACKW_CNT   = CNT_W'(1);
    localparam logic [CNT_W-1:0] FIN_CNT    = CNT_W'(2 * FINISH_BUS - 1);
    localparam logic [CNT_W-1:0] HOLD_CNT   = CNT_W'(2 * HOLD_BUS - 1);

    bus_state_e       st, nxt_st;
    logic [CNT_W-1:0] cnt, nxt_cnt;
    logic [CNT_W-1:0] wait_cnt;
    bus_state_e       end_st;
    logic [CNT_W-1:0] end_cnt;

    assign wait_cnt = CNT_W'({waits, 1'b0}) - CNT_W'(1);

    // where the strobe goes once its fixed part is used up
    always_comb begin
        if (!uses_ack(mode)) begin
            end_st  = ST_RELEASE;
            end_cnt = '0;
        end else if (bus_ack) begin
            end_st  = ST_FINISH;
            end_cnt = FIN_CNT;
        end else begin
            end_st  = ST_ACKW;
            end_cnt = ACKW_CNT;
        end
    end

    always_comb begin
        nxt_st  = st;
        nxt_cnt = cnt;
        if (cnt != '0) begin
            nxt_cnt = cnt - CNT_W'(1);
        end else begin
            unique case (st)
                ST_IDLE: if (req_valid) begin
                    nxt_st  = ST_SETUP;
                    nxt_cnt = '0;
                end
                ST_SETUP: begin
                    nxt_st  = ST_STROBE;
                    nxt_cnt = STROBE_CNT;
                end
                ST_STROBE: if (uses_waits(mode) && waits != '0) begin
                    nxt_st  = ST_WAIT;
                    nxt_cnt = wait_cnt;
                end else begin
                    nxt_st  = end_st;
                    nxt_cnt = end_cnt;
                end
                ST_WAIT, ST_ACKW: begin
                    nxt_st  = end_st;
                    nxt_cnt = end_cnt;
                end
                ST_FINISH: begin
                    nxt_st  = ST_RELEASE;
                    nxt_cnt = '0;
                end
                ST_RELEASE: if (hold) begin
                    nxt_st  = ST_HOLD;
                    nxt_cnt = HOLD_CNT;
                end else begin
                    nxt_st = ST_IDLE;
                end
                ST_HOLD: nxt_st = ST_IDLE;
                default: nxt_st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            st  <= nxt_st;
            cnt <= nxt_cnt;
        end
    end

    assign state  = st;
    assign accept = (st == ST_IDLE) && req_valid;
    assign done   = (cnt == '0) &&
                    ((st == ST_HOLD) || (st == ST_RELEASE && !hold));

    // R10: ready lasts a single clock and is followed by idle
    assert_ready_single_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && st == ST_IDLE));

    // R10: an accepted request moves straight into setup
    assert_accept_setup_R10: assert property (@(posedge clk) disable iff (rst)
        accept |=> (st == ST_SETUP));

    // R6: a low acknowledge sample never skips to the finish phase
    assert_ack_low_waits_R6: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ACKW && cnt == '0 && !bus_ack) |=> (st == ST_ACKW));
endmodule

// File: rtl/ebw_pins.sv
module ebw_pins
    import ebw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_state_e        state,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [DATA_W-1:0] data_q,
    input  logic [SEL_W-1:0]  sel_q,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe,
    output logic [NUM_MS-1:0] bus_ms_n,
    output logic              bus_io_n,
    output logic              bus_boot_n,
    output logic              bus_wr_n,
    output logic              bus_rd_n
);
    logic              cs_on;
    logic              strobe_on;
    logic [NUM_CS-1:0] cs_hot;
    logic [NUM_CS-1:0] cs_act;

    always_comb begin
        unique case (state)
            ST_SETUP, ST_RELEASE:                      begin cs_on = 1'b1; strobe_on = 1'b0; end
            ST_STROBE, ST_WAIT, ST_ACKW, ST_FINISH:    begin cs_on = 1'b1; strobe_on = 1'b1; end
            default:                                   begin cs_on = 1'b0; strobe_on = 1'b0; end
        endcase
    end

    assign cs_hot = sel_decode(sel_q);

    generate
        for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
            assign cs_act[i] = cs_on & cs_hot[i];
        end
        for (genvar m = 0; m < NUM_MS; m++) begin : g_ms
            assign bus_ms_n[m] = ~cs_act[m];
        end
    endgenerate

    assign bus_io_n   = ~cs_act[NUM_MS];
    assign bus_boot_n = ~cs_act[NUM_MS+1];
    assign bus_wr_n   = ~strobe_on;
    assign bus_rd_n   = 1'b1;
    assign bus_doe    = strobe_on || state == ST_RELEASE || state == ST_HOLD;
    assign bus_addr   = addr_q;
    assign bus_dout   = data_q;

    logic any_sel;
    assign any_sel = (bus_ms_n != '1) || !bus_io_n || !bus_boot_n;

    // R2: never more than one select low
    assert_one_select_R2: assert property (@(posedge clk) disable iff (rst)
        $countones({~bus_ms_n, ~bus_io_n, ~bus_boot_n}) <= 1);

    // R2: a strobe always has a select under it
    assert_strobe_has_select_R2: assert property (@(posedge clk) disable iff (rst)
        !bus_wr_n |-> any_sel);

    // R3: select was already low one clock before the strobe falls
    assert_select_leads_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_wr_n) |-> $past(any_sel));

    // R4: select and address outlast the strobe by one clock
    assert_select_trails_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_wr_n) |-> (any_sel && $stable(bus_addr)));

    // R8: data pads driven whenever the strobe is low
    assert_data_on_strobe_R8: assert property (@(posedge clk) disable iff (rst)
        !bus_wr_n |-> (bus_doe && $stable(bus_dout)));
endmodule

// File: rtl/ebw_write_ctrl.sv
module ebw_write_ctrl
    import ebw_pkg::*;
#(
    parameter int FINISH_BUS = 2,
    parameter int HOLD_BUS   = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic [SEL_W-1:0]  req_sel,
    input  logic [1:0]        cfg_mode,
    input  logic [WS_W-1:0]   cfg_waits,
    input  logic              cfg_hold,
    input  logic              bus_ack,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe,
    output logic [NUM_MS-1:0] bus_ms_n,
    output logic              bus_io_n,
    output logic              bus_boot_n,
    output logic              bus_wr_n,
    output logic              bus_rd_n
);
    wr_req_t    req_in;
    wr_req_t    req_q;
    logic       accept;
    bus_state_e state;

    assign req_in = '{addr:  req_addr,
                      data:  req_data,
                      sel:   req_sel,
                      mode:  ext_mode_e'(cfg_mode),
                      waits: cfg_waits,
                      hold:  cfg_hold};

    ebw_req_latch u_latch (
        .clk    (clk),
        .rst    (rst),
        .load   (accept),
        .req_in (req_in),
        .req_q  (req_q)
    );

    ebw_seq #(
        .FINISH_BUS (FINISH_BUS),
        .HOLD_BUS   (HOLD_BUS)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .bus_ack   (bus_ack),
        .mode      (req_q.mode),
        .waits     (req_q.waits),
        .hold      (req_q.hold),
        .accept    (accept),
        .done      (req_ready),
        .state     (state)
    );

    ebw_pins u_pins (
        .clk        (clk),
        .rst        (rst),
        .state      (state),
        .addr_q     (req_q.addr),
        .data_q     (req_q.data),
        .sel_q      (req_q.sel),
        .bus_addr   (bus_addr),
        .bus_dout   (bus_dout),
        .bus_doe    (bus_doe),
        .bus_ms_n   (bus_ms_n),
        .bus_io_n   (bus_io_n),
        .bus_boot_n (bus_boot_n),
        .bus_wr_n   (bus_wr_n),
        .bus_rd_n   (bus_rd_n)
    );

    // run of strobe-high clocks, saturating at 3
    logic [1:0] hi_run;
    always_ff @(posedge clk) begin
        if (rst)
            hi_run <= 2'd3;
        else if (!bus_wr_n)
            hi_run <= 2'd0;
        else if (hi_run != 2'd3)
            hi_run <= hi_run + 2'd1;
    end

    // R11: one bus period of recovery between strobes
    assert_recovery_gap_R11: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_wr_n) |-> (hi_run >= 2'd2));

    // R1: nothing is driven while idle
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> (bus_wr_n && bus_rd_n && !bus_doe && !req_ready &&
                                bus_ms_n == '1 && bus_io_n && bus_boot_n));
endmodule

// File: tb/sim_ebw_write_ctrl.sv
`timescale 1ns/1ps
module sim_ebw_write_ctrl;
    import ebw_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_data = '0;
    logic [SEL_W-1:0]  req_sel = '0;
    logic [1:0]        cfg_mode = 2'b00;
    logic [WS_W-1:0]   cfg_waits = '0;
    logic              cfg_hold = 1'b0;
    logic              bus_ack = 1'b1;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_dout;
    logic              bus_doe;
    logic [NUM_MS-1:0] bus_ms_n;
    logic              bus_io_n;
    logic              bus_boot_n;
    logic              bus_wr_n;
    logic              bus_rd_n;

    always #4 clk = ~clk;

    ebw_write_ctrl u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data), .req_sel(req_sel),
        .cfg_mode(cfg_mode), .cfg_waits(cfg_waits), .cfg_hold(cfg_hold),
        .bus_ack(bus_ack), .bus_addr(bus_addr), .bus_dout(bus_dout),
        .bus_doe(bus_doe), .bus_ms_n(bus_ms_n), .bus_io_n(bus_io_n),
        .bus_boot_n(bus_boot_n), .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n)
    );

    int vectors = 0;
    int fails   = 0;

    task automatic check(string req, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    typedef struct {
        int                code;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        int                wr_len;
        int                oe_len;
        int                post;
        bit                first;
    } exp_t;

    exp_t exp_q[$];
    bit   first_sent = 1'b0;

    // driver: queue the expectation, present the request, steer acknowledge
    task automatic do_write(int sel, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d,
                            int mode, int w, bit hold, int k, bit ack_low_all);
        exp_t e;
        int   we;
        bit   ackm;
        we   = (mode != 1) ? w : 0;
        ackm = (mode != 0);
        e.code   = (sel > 5) ? 5 : sel;
        e.addr   = a;
        e.data   = d;
        e.wr_len = 2 + 2 * we + (ackm ? (2 * k + 4) : 0);
        e.oe_len = e.wr_len + 1 + (hold ? 2 : 0);
        e.post   = hold ? 3 : 1;
        e.first  = !first_sent;
        first_sent = 1'b1;
        exp_q.push_back(e);
        @(negedge clk);
        req_addr  = a;
        req_data  = d;
        req_sel   = SEL_W'(sel);
        cfg_mode  = 2'(mode);
        cfg_waits = WS_W'(w);
        cfg_hold  = hold;
        req_valid = 1'b1;
        do @(negedge clk); while (bus_wr_n);
        if (ack_low_all) begin
            bus_ack = 1'b0;
        end else if (ackm && k > 0) begin
            bus_ack = 1'b0;
            repeat (2 * we + 2 * k) @(negedge clk);
            bus_ack = 1'b1;
        end
        while (!req_ready) @(negedge clk);
        req_valid = 1'b0;
        bus_ack   = 1'b1;
    endtask

    // monitor: measure each access on falling edges, compare when ready shows
    int                wr_cnt = 0, cs_cnt = 0, lead = 0, oe_cnt = 0, post = 0;
    int                hi_gap = 100, gap_at = 0, seen_code = -1, multi = 0;
    logic [ADDR_W-1:0] addr_s = '0;
    logic [DATA_W-1:0] data_s = '0;

    always @(negedge clk) begin
        if (!rst) begin
            int nsel;
            int code;
            nsel = 0;
            code = -1;
            for (int i = 0; i < NUM_MS; i++) begin
                if (!bus_ms_n[i]) begin nsel++; code = i; end
            end
            if (!bus_io_n)   begin nsel++; code = NUM_MS; end
            if (!bus_boot_n) begin nsel++; code = NUM_MS + 1; end
            if (nsel > 1) multi = 1;
            if (!bus_wr_n) begin
                if (wr_cnt == 0) begin
                    addr_s    = bus_addr;
                    data_s    = bus_dout;
                    seen_code = code;
                    gap_at    = hi_gap;
                end
                wr_cnt++;
                hi_gap = 0;
            end else if (hi_gap < 100) begin
                hi_gap++;
            end
            if (nsel != 0) begin
                cs_cnt++;
                if (wr_cnt == 0) lead++;
            end
            if (bus_doe) oe_cnt++;
            if (bus_wr_n && wr_cnt > 0) post++;
            if (req_ready) begin
                if (exp_q.size() == 0) begin
                    check("R10 unexpected ready", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check("R2 select code", seen_code, e.code);
                    check("R2 single select", multi, 0);
                    check("R3 address", int'(addr_s), int'(e.addr));
                    check("R8 data", int'(data_s), int'(e.data));
                    check("R5 R6 R7 strobe length", wr_cnt, e.wr_len);
                    check("R3 select lead", lead, 1);
                    check("R4 select length", cs_cnt, e.wr_len + 2);
                    check("R8 R9 output-enable length", oe_cnt, e.oe_len);
                    check("R10 ready position", post, e.post);
                    if (!e.first)
                        check("R11 recovery gap", (gap_at >= 2) ? 1 : 0, 1);
                end
                wr_cnt = 0; cs_cnt = 0; lead = 0; oe_cnt = 0; post = 0; multi = 0;
            end
        end
    end

    task automatic check_quiet(string req);
        check({req, " wr_n"}, int'(bus_wr_n), 1);
        check({req, " rd_n"}, int'(bus_rd_n), 1);
        check({req, " selects"}, int'({bus_ms_n, bus_io_n, bus_boot_n}), 63);
        check({req, " doe"}, int'(bus_doe), 0);
        check({req, " ready"}, int'(req_ready), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        req_valid = 1'b1;      // R1: request during reset must be ignored
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_quiet("R1 in reset");
        req_valid = 1'b0;
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check_quiet("R1 idle");

        // R5: waitstates only, W = 0
        do_write(0, 22'h000123, 16'hA5A5, 0, 0, 1'b0, 0, 1'b0);
        // R5: W = 3, acknowledge held low must not matter
        do_write(1, 22'h2AAAAA, 16'h1234, 0, 3, 1'b0, 0, 1'b1);
        // R5 R9: W = 7 with write hold, I/O select
        do_write(4, 22'h155555, 16'hFFFF, 0, 7, 1'b1, 0, 1'b0);
        // R6: acknowledge only, W ignored, no low samples
        do_write(2, 22'h3FFFFF, 16'h0001, 1, 5, 1'b0, 0, 1'b0);
        // R6: acknowledge only, three low samples
        do_write(3, 22'h0F0F0F, 16'h8000, 1, 0, 1'b0, 3, 1'b0);
        // R7: combined, W = 2, one low sample, boot select
        do_write(5, 22'h000001, 16'h5A5A, 2, 2, 1'b0, 1, 1'b0);
        // R7 R9: combined via alternate code, code 7 maps to boot
        do_write(7, 22'h200000, 16'hC3C3, 3, 1, 1'b1, 0, 1'b0);
        // R2 R9: code 6 maps to boot, hold with shortest strobe
        do_write(6, 22'h123456, 16'h0F0F, 0, 0, 1'b1, 0, 1'b0);

        repeat (4) @(negedge clk);
        check_quiet("R1 after traffic");
        check("R10 all accesses completed", exp_q.size(), 0);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule